// File: doc/BRIEF.md
# Double-Buffered Raster Line Fetcher

This block feeds a display from memory through two line buffers, keeping memory reads apart from pixel decoding. While the serializer steps through one buffer at the display's pixel rate, a fetch engine acts as bus master and fills the other buffer with the words of the coming scanline. It issues one word per granted bus cycle and withdraws its request as soon as the line is complete, so other masters get every remaining cycle.

A line strobe marks horizontal blanking. On that strobe the two buffers trade roles, the serializer restarts at pixel zero of the freshly filled line, and the fetcher starts on the following line at the previous line address plus a programmable stride. A frame strobe sends the fetcher back to a programmable frame base. The serializer unpacks buffer words at 1, 2, 4, 8 or 16 bits per pixel and presents a raw 16-bit pixel index. Palette lookup and sync timing are left to neighbouring blocks.

Top module: `raster_line_fetcher`

## Requirements
- R1: One cycle after `frame_sync`, `bus_req` is high with `bus_addr` equal to `cfg_base`, `pix_valid` is low and `underrun` is low.
- R2: A line holds `cfg_hpix * bpp / 16` words, where bpp = 2^`cfg_depth` for codes 0 to 4; codes 5, 6 and 7 behave as code 4 (16 bits per pixel).
- R3: A word transfers in each cycle where `bus_req` and `bus_gnt` are both high; `bus_rdata` is taken in that same cycle, and `bus_addr` then rises by one. Without a grant, `bus_addr` holds.
- R4: `bus_req` is low in the cycle after the last word of a line transfers, unless a strobe starts a new fetch in that cycle.
- R5: On `line_sync` the buffers swap: from the next cycle `pix_valid` is high and `pix_out` shows pixel 0 of the line just filled, and the fetcher requests the next line at the previous line address plus `cfg_stride`.
- R6: If a fetch is unfinished at `line_sync`, `underrun` becomes 1 and the unfinished fetch is abandoned; a last word granted in the same cycle as `line_sync` counts as finished. `underrun` stays set until the next `frame_sync`.
- R7: When `frame_sync` and `line_sync` arrive together, `frame_sync` wins: no swap occurs, no underrun is raised and the fetch restarts at `cfg_base`.
- R8: Pixels are unpacked from the most significant end of each word first; bits of `pix_out` above the pixel width are zero.
- R9: The serializer moves to the next pixel on each cycle with `dot_en` high, and `pix_valid` falls after `cfg_hpix` pixels have been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and pixel logic |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Color depth code, bpp = 2^code, codes above 4 act as 4 |
| cfg_hpix | input | HPIX_W | Pixels per visible line |
| cfg_base | input | ADDR_W | Word address of the frame's first line |
| cfg_stride | input | ADDR_W | Word distance between line starts |
| frame_sync | input | 1 | Start-of-frame strobe |
| line_sync | input | 1 | Horizontal blank strobe, swaps buffers |
| dot_en | input | 1 | Pixel advance enable |
| bus_req | output | 1 | Fetch request to the bus arbiter |
| bus_gnt | input | 1 | Grant; a word transfers when request and grant are high |
| bus_addr | output | ADDR_W | Word address of the current fetch |
| bus_rdata | input | 16 | Read data for `bus_addr` in the granted cycle |
| pix_out | output | 16 | Raw pixel index |
| pix_valid | output | 1 | High while line pixels are being shown |
| underrun | output | 1 | Sticky flag: a line was not fetched in time |

## Verification
The interesting collisions are a line strobe landing in the very cycle the fetcher's last word is granted, and a line strobe landing together with a frame strobe. The first is provoked by granting every cycle and raising `line_sync` exactly with the final grant; it is judged by `underrun` staying low and pixel 0 of the new line matching the memory model's word. The second is provoked while a fetch is half-done and is judged by `underrun` staying clear, `pix_valid` staying low and the request restarting at the frame base.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int WORD_W = 16;

  // Depth codes above 4 are treated as 16 bits per pixel.
  function automatic logic [2:0] eff_depth(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  // Words per line: pixels times bits per pixel over the word width.
  function automatic int unsigned words_per_line(input int unsigned hpix,
                                                 input logic [2:0] code);
    int unsigned bits;
    bits = hpix << eff_depth(code);
    return bits >> 4;
  endfunction

  // Extract pixel number slot from a word, most significant pixel first.
  function automatic logic [WORD_W-1:0] unpack_pixel(input logic [WORD_W-1:0] w,
                                                     input logic [3:0] slot,
                                                     input logic [2:0] code);
    logic [2:0]  d;
    logic [4:0]  bpp;
    logic [4:0]  shift;
    logic [WORD_W-1:0] mask;
    d     = eff_depth(code);
    bpp   = 5'd1 << d;
    shift = 5'd16 - (bpp * (5'(slot) + 5'd1));
    mask  = (d == 3'd4) ? 16'hFFFF : ((16'd1 << bpp) - 16'd1);
    return (w >> shift) & mask;
  endfunction

endpackage

// File: rtl/raster_fetch.sv
module raster_fetch #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_sync,
  input  logic [CNT_W-1:0]  n_words,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              fill_sel,
  output logic              fetch_done,
  output logic [ADDR_W-1:0] line_base,
  output logic              underrun
);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic              xfer;
  logic              late;
  logic [ADDR_W-1:0] next_line;

  assign xfer       = busy & bus_gnt;
  assign fetch_done = xfer && (cnt == n_words - CNT_W'(1));
  assign late       = line_sync && !frame_sync && busy && !fetch_done;
  assign next_line  = line_base + cfg_stride;

  assign bus_req = busy;
  assign wr_en   = xfer;
  assign wr_idx  = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      bus_addr  <= '0;
      line_base <= '0;
      fill_sel  <= 1'b0;
      underrun  <= 1'b0;
    end else if (frame_sync) begin
      busy      <= (n_words != '0);
      cnt       <= '0;
      bus_addr  <= cfg_base;
      line_base <= cfg_base;
      underrun  <= 1'b0;
    end else if (line_sync) begin
      fill_sel  <= ~fill_sel;
      busy      <= (n_words != '0);
      cnt       <= '0;
      bus_addr  <= next_line;
      line_base <= next_line;
      if (late) underrun <= 1'b1;
    end else if (xfer) begin
      cnt      <= cnt + CNT_W'(1);
      bus_addr <= bus_addr + ADDR_W'(1);
      if (fetch_done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_linebuf.sv
module raster_linebuf #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/raster_serializer.sv
module raster_serializer
  import raster_pkg::*;
#(
  parameter int HPIX_W = 11,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              line_sync,
  input  logic              dot_en,
  input  logic [2:0]        cfg_depth,
  input  logic [HPIX_W-1:0] cfg_hpix,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [15:0]       rd_data,
  output logic [15:0]       pix_out,
  output logic              pix_valid
);

  logic              active;
  logic [HPIX_W-1:0] pcount;
  logic [2:0]        d;
  logic [HPIX_W-1:0] widx;
  logic [3:0]        slot;
  logic [3:0]        slot_mask;

  always_comb begin
    d         = eff_depth(cfg_depth);
    widx      = pcount >> (3'd4 - d);
    slot_mask = 4'hF >> d;
    slot      = pcount[3:0] & slot_mask;
    rd_idx    = widx[IDX_W-1:0];
    pix_out   = active ? unpack_pixel(rd_data, slot, cfg_depth) : '0;
  end

  assign pix_valid = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pcount <= '0;
    end else if (frame_sync) begin
      active <= 1'b0;
      pcount <= '0;
    end else if (line_sync) begin
      active <= (cfg_hpix != '0);
      pcount <= '0;
    end else if (active && dot_en) begin
      if (pcount == cfg_hpix - HPIX_W'(1)) active <= 1'b0;
      else pcount <= pcount + HPIX_W'(1);
    end
  end

endmodule

// File: rtl/raster_line_fetcher.sv
module raster_line_fetcher
  import raster_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int HPIX_W    = 11,
  parameter int BUF_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic [HPIX_W-1:0] cfg_hpix,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              frame_sync,
  input  logic              line_sync,
  input  logic              dot_en,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_rdata,
  output logic [15:0]       pix_out,
  output logic              pix_valid,
  output logic              underrun
);

  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [CNT_W-1:0]  n_words;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              fill_sel;
  logic              fetch_done;
  logic [ADDR_W-1:0] line_base;
  logic [IDX_W-1:0]  rd_idx;
  logic [15:0]       rd_word [2];
  logic [15:0]       show_word;

  always_comb begin
    int unsigned w;
    w = words_per_line(int'(cfg_hpix), cfg_depth);
    n_words = (w > BUF_DEPTH) ? CNT_W'(BUF_DEPTH) : CNT_W'(w);
  end

  raster_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .line_sync  (line_sync),
    .n_words    (n_words),
    .cfg_base   (cfg_base),
    .cfg_stride (cfg_stride),
    .bus_gnt    (bus_gnt),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .fill_sel   (fill_sel),
    .fetch_done (fetch_done),
    .line_base  (line_base),
    .underrun   (underrun)
  );

  for (genvar g = 0; g < 2; g++) begin : g_buf
    raster_linebuf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
      .clk     (clk),
      .wr_en   (wr_en && (fill_sel == 1'(g))),
      .wr_idx  (wr_idx),
      .wr_data (bus_rdata),
      .rd_idx  (rd_idx),
      .rd_data (rd_word[g])
    );
  end

  assign show_word = fill_sel ? rd_word[0] : rd_word[1];

  raster_serializer #(.HPIX_W(HPIX_W), .IDX_W(IDX_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .line_sync  (line_sync),
    .dot_en     (dot_en),
    .cfg_depth  (cfg_depth),
    .cfg_hpix   (cfg_hpix),
    .rd_idx     (rd_idx),
    .rd_data    (show_word),
    .pix_out    (pix_out),
    .pix_valid  (pix_valid)
  );

endmodule

// File: rtl/raster_line_fetcher_chk.sv
module raster_line_fetcher_chk #(
  parameter int ADDR_W = 20,
  parameter int HPIX_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cfg_depth,
  input logic [HPIX_W-1:0] cfg_hpix,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [ADDR_W-1:0] cfg_stride,
  input logic              frame_sync,
  input logic              line_sync,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       pix_out,
  input logic              pix_valid,
  input logic              underrun,
  input logic              fetch_done,
  input logic [ADDR_W-1:0] line_base
);

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (bus_addr == $past(cfg_base)) && !pix_valid && !underrun); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !fetch_done && !line_sync && !frame_sync)
      |=> bus_addr == $past(bus_addr) + ADDR_W'(1)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !line_sync && !frame_sync) |=> $stable(bus_addr)); // R3

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !line_sync && !frame_sync) |=> !bus_req); // R4

  AST_LINE_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && !frame_sync)
      |=> line_base == $past(line_base) + $past(cfg_stride)); // R5

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !frame_sync) |=> underrun); // R6

  AST_FRAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && line_sync) |=> !underrun && !pix_valid); // R7

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cfg_depth == 3'd0) |-> pix_out[15:1] == 15'd0); // R8

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hpix != '0 || !pix_valid) |-> (pix_valid || pix_out == 16'd0)); // R9

endmodule

bind raster_line_fetcher raster_line_fetcher_chk #(.ADDR_W(ADDR_W), .HPIX_W(HPIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_depth  (cfg_depth),
  .cfg_hpix   (cfg_hpix),
  .cfg_base   (cfg_base),
  .cfg_stride (cfg_stride),
  .frame_sync (frame_sync),
  .line_sync  (line_sync),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_addr   (bus_addr),
  .pix_out    (pix_out),
  .pix_valid  (pix_valid),
  .underrun   (underrun),
  .fetch_done (fetch_done),
  .line_base  (line_base)
);

// File: tb/sim_raster_line_fetcher.sv
`timescale 1ns/1ps
module sim_raster_line_fetcher;

  localparam int ADDR_W = 20;
  localparam int HPIX_W = 11;
  localparam int NV = 6;

  localparam int V_DEPTH  [NV] = '{0, 1, 2, 3, 4, 7};
  localparam int V_HPIX   [NV] = '{64, 32, 32, 16, 16, 8};
  localparam int V_BASE   [NV] = '{100, 512, 7, 4000, 50, 1234};
  localparam int V_STRIDE [NV] = '{40, 8, 16, 300, 1, 20};
  localparam int V_GAP    [NV] = '{0, 1, 2, 0, 3, 1};
  localparam int V_WORDS  [NV] = '{4, 4, 8, 8, 16, 8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_depth = '0;
  logic [HPIX_W-1:0] cfg_hpix = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [ADDR_W-1:0] cfg_stride = '0;
  logic frame_sync = 1'b0, line_sync = 1'b0, dot_en = 1'b0, bus_gnt = 1'b0;
  logic bus_req, pix_valid, underrun;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0] bus_rdata, pix_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [15:0] lo;
    lo = a[15:0] * 16'h9E37;
    return lo ^ {a[19:16], 12'h0} ^ 16'hC35A;
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  raster_line_fetcher #(.ADDR_W(ADDR_W), .HPIX_W(HPIX_W), .BUF_DEPTH(64)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_hpix(cfg_hpix),
    .cfg_base(cfg_base), .cfg_stride(cfg_stride), .frame_sync(frame_sync),
    .line_sync(line_sync), .dot_en(dot_en), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pix_out(pix_out),
    .pix_valid(pix_valid), .underrun(underrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // Pixel i of a line as a bit stream, most significant bit of each word first.
  function automatic int exp_pixel(input int base, input int depth, input int i);
    int bpp, bitpos, off;
    logic [15:0] w;
    bpp    = 1 << ((depth > 4) ? 4 : depth);
    bitpos = i * bpp;
    w      = mem_word(ADDR_W'(base + bitpos / 16));
    off    = bitpos % 16;
    return int'((w >> (16 - off - bpp))) & ((1 << bpp) - 1);
  endfunction

  task automatic pulse_frame;
    frame_sync = 1'b1; tick; frame_sync = 1'b0;
  endtask

  initial begin
    repeat (3) tick;
    chk("R1 reset bus_req", int'(bus_req), 0);
    chk("R1 reset pix_valid", int'(pix_valid), 0);
    chk("R6 reset underrun", int'(underrun), 0);
    rst_n = 1'b1;
    tick;

    for (int v = 0; v < NV; v++) begin
      int nx, gcyc, guard;
      cfg_depth  = 3'(V_DEPTH[v]);
      cfg_hpix   = HPIX_W'(V_HPIX[v]);
      cfg_base   = ADDR_W'(V_BASE[v]);
      cfg_stride = ADDR_W'(V_STRIDE[v]);
      bus_gnt    = 1'b0;
      pulse_frame;
      chk("R1 request after frame", int'(bus_req), 1);
      chk("R1 start address", int'(bus_addr), V_BASE[v]);
      nx = 0; gcyc = 0; guard = 0;
      while (bus_req && guard < 500) begin
        bus_gnt = ((gcyc % (V_GAP[v] + 1)) == 0);
        if (bus_gnt) begin
          chk("R3 word address", int'(bus_addr), V_BASE[v] + nx);
          nx++;
        end
        gcyc++; guard++;
        tick;
      end
      bus_gnt = 1'b0;
      chk("R2 R4 words then release", nx, V_WORDS[v]);
      line_sync = 1'b1; tick; line_sync = 1'b0;
      chk("R5 pix_valid after swap", int'(pix_valid), 1);
      chk("R5 next line address", int'(bus_addr), V_BASE[v] + V_STRIDE[v]);
      dot_en = 1'b1;
      for (int i = 0; i < V_HPIX[v]; i++) begin
        if (pix_out != 16'(exp_pixel(V_BASE[v], V_DEPTH[v], i)))
          chk("R8 pixel value", int'(pix_out), exp_pixel(V_BASE[v], V_DEPTH[v], i));
        else checks++;
        tick;
      end
      dot_en = 1'b0;
      chk("R9 line end", int'(pix_valid), 0);
      chk("R6 no underrun yet", int'(underrun), 0);
      line_sync = 1'b1; tick; line_sync = 1'b0;
      chk("R6 late fetch flags underrun", int'(underrun), 1);
      tick;
      chk("R6 underrun sticky", int'(underrun), 1);
    end

    // dot_en low holds the pixel
    cfg_depth = 3'd3; cfg_hpix = HPIX_W'(16); cfg_base = ADDR_W'(300); cfg_stride = ADDR_W'(10);
    pulse_frame;
    bus_gnt = 1'b1;
    while (bus_req) tick;
    bus_gnt = 1'b0;
    line_sync = 1'b1; tick; line_sync = 1'b0;
    repeat (3) tick;
    chk("R9 hold without dot_en", int'(pix_out), exp_pixel(300, 3, 0));
    dot_en = 1'b1; tick; dot_en = 1'b0;
    chk("R9 advance on dot_en", int'(pix_out), exp_pixel(300, 3, 1));

    // last word granted in the line_sync cycle
    cfg_depth = 3'd4; cfg_hpix = HPIX_W'(16); cfg_base = ADDR_W'(900); cfg_stride = ADDR_W'(64);
    pulse_frame;
    chk("R1 underrun cleared", int'(underrun), 0);
    bus_gnt = 1'b1;
    repeat (15) tick;
    chk("R3 fetch still open", int'(bus_req), 1);
    line_sync = 1'b1; tick; line_sync = 1'b0; bus_gnt = 1'b0;
    chk("R6 last word with swap no underrun", int'(underrun), 0);
    chk("R6 new line shown", int'(pix_out), exp_pixel(900, 4, 0));
    chk("R5 fetch of next line", int'(bus_addr), 964);

    // frame and line strobes together while a fetch is half-done
    bus_gnt = 1'b1; repeat (5) tick; bus_gnt = 1'b0;
    frame_sync = 1'b1; line_sync = 1'b1; tick;
    frame_sync = 1'b0; line_sync = 1'b0;
    chk("R7 no underrun", int'(underrun), 0);
    chk("R7 no display", int'(pix_valid), 0);
    chk("R7 restart at base", int'(bus_addr), 900);
    chk("R7 request open", int'(bus_req), 1);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule